// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a general-purpose interval timer. A 5-bit prescaler advances on an incoming clock-enable pulse. That pulse is expected to arrive at one eighth of the peripheral clock rate. Three bits of the prescaler give tap enables at the prescaler rate divided by 2, 8 and 32. A 2-bit select field routes one of the taps to a 16-bit up counter.

The prescaler and the counter each have their own run input. Dropping either run input clears that stage to zero. The counter can run freely and wrap, or it can return to zero on the tick after it equals a compare value, which gives a periodic timebase. Two single-cycle pulses report events: a compare match and a wrap from the maximum value to zero.

Everything runs on one clock and is advanced only by enable pulses. No divided clocks are created.

Top module: `tmr16_presc`

## Requirements
- R1: While `psc_run` is 1, the prescaler increments by one on every cycle where `base_tick` is 1, and wraps modulo 32. Cycles without `base_tick` leave it unchanged.
- R2: While `psc_run` is 0, the prescaler is forced to 0 and produces no taps, so the counter holds its value. When `psc_run` returns to 1, the prescaler counts again from 0.
- R3: `src_sel` picks which prescaler bit feeds the counter: 2'b01 selects bit 0, 2'b10 selects bit 2 and 2'b11 selects bit 4. The counter advances once on each prescaler increment that takes the selected bit from 0 to 1. That gives one count per 2, 8 or 32 base ticks.
- R4: `src_sel` = 2'b00 selects no source, and the counter holds its value.
- R5: While `cnt_run` is 0, the counter is cleared to 0 at the next clock edge and stays at 0.
- R6: With `wrap_on_cmp` at 1, a selected tick that finds the counter equal to `cmp_val` loads 0 instead of incrementing.
- R7: With `wrap_on_cmp` at 0, the counter free-runs through 16'hFFFF back to 0.
- R8: `cmp_hit` is a one-cycle pulse. It appears in the cycle the counter takes its next value after a selected tick that found the counter equal to `cmp_val`, whatever the setting of `wrap_on_cmp`.
- R9: `ovf_irq` is a one-cycle pulse. It appears in the cycle the counter goes from 16'hFFFF to 0 by incrementing, and it is not raised by a compare clear.
- R10: A low `rst_n` at a clock edge clears the prescaler, the counter and both pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_tick | input | 1 | Enable pulse at one eighth of the peripheral clock rate |
| psc_run | input | 1 | Prescaler run; 0 clears and holds the prescaler |
| cnt_run | input | 1 | Counter run; 0 clears and holds the counter |
| src_sel | input | 2 | Counter source: 00 none, 01 /2, 10 /8, 11 /32 |
| wrap_on_cmp | input | 1 | Return the counter to 0 after a compare match |
| cmp_val | input | 16 | Compare value |
| count | output | 16 | Current counter value |
| cmp_hit | output | 1 | One-cycle compare match pulse |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The wrap from 16'hFFFF to zero is the hardest case to reach from the ports, because the counter has no load path and must step through every value. The stimulus holds `base_tick` high and selects the /2 tap, so the counter advances every second cycle and reaches the wrap in about 131 thousand cycles. The compare value is set to the midpoint of that run, so a match without clearing and the overflow pulse are both checked against exact expected cycle numbers in a single pass.

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 5,
  parameter int TAP_A = 0,
  parameter int TAP_B = 2,
  parameter int TAP_C = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             psc_run,
  input  logic             cnt_run,
  input  logic [1:0]       src_sel,
  input  logic             wrap_on_cmp,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             cmp_hit,
  output logic             ovf_irq
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_nx;
  logic [PSC_W-1:0] rise;
  logic             adv;
  logic             step;
  logic [CNT_W-1:0] cnt_q;
  logic             at_cmp;
  logic             at_top;

  assign adv    = base_tick & psc_run;
  assign psc_nx = psc_q + 1'b1;
  assign rise   = {PSC_W{adv}} & ~psc_q & psc_nx;

  always_ff @(posedge clk) begin
    if (!rst_n || !psc_run) psc_q <= '0;
    else if (adv)           psc_q <= psc_nx;
  end

  always_comb begin
    unique case (src_sel)
      2'b01:   step = rise[TAP_A];
      2'b10:   step = rise[TAP_B];
      2'b11:   step = rise[TAP_C];
      default: step = 1'b0;
    endcase
  end

  assign at_cmp = (cnt_q == cmp_val);
  assign at_top = (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n || !cnt_run) begin
      cnt_q   <= '0;
      cmp_hit <= 1'b0;
      ovf_irq <= 1'b0;
    end else begin
      cmp_hit <= step & at_cmp;
      ovf_irq <= step & at_top & ~(wrap_on_cmp & at_cmp);
      if (step) cnt_q <= (wrap_on_cmp && at_cmp) ? '0 : cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!psc_run && cnt_run) |=> $stable(cnt_q));

  p_no_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00 && cnt_run) |=> $stable(cnt_q));

  p_run_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_run |=> (cnt_q == '0));

  p_clear_or_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |-> ($past(wrap_on_cmp) ? (cnt_q == '0) : (cnt_q == $past(cnt_q) + 1'b1)));

  p_single_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> !cmp_hit);

  p_wrap_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (cnt_q == '0 && $past(cnt_q) == {CNT_W{1'b1}}));

endmodule

// File: tb/tmr16_presc_test.sv
module tmr16_presc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        psc_run = 1'b0;
  logic        cnt_run = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic        wrap_on_cmp = 1'b0;
  logic [15:0] cmp_val = 16'h1234;
  logic [15:0] count;
  logic        cmp_hit;
  logic        ovf_irq;

  int nchk = 0;
  int nerr = 0;
  int ecnt = 0;
  int base = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  tmr16_presc uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .psc_run(psc_run),
    .cnt_run(cnt_run), .src_sel(src_sel), .wrap_on_cmp(wrap_on_cmp),
    .cmp_val(cmp_val), .count(count), .cmp_hit(cmp_hit), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] sel, input logic clr, input logic [15:0] cv, input logic tk);
    psc_run = 1'b0; cnt_run = 1'b0;
    @(negedge clk);
    src_sel = sel; wrap_on_cmp = clr; cmp_val = cv;
    psc_run = 1'b1; cnt_run = 1'b1; base_tick = tk;
    base = ecnt;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_evt(input int offs, input int kind);
    exp_q.push_back((base + offs) * 2 + kind);
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_hit) begin
      if (exp_q.size() == 0) check("R8 unexpected cmp_hit", ecnt, -1);
      else check("R8 cmp_hit edge", ecnt * 2, exp_q.pop_front());
    end
    if (rst_n && ovf_irq) begin
      if (exp_q.size() == 0) check("R9 unexpected ovf_irq", ecnt, -1);
      else check("R9 ovf_irq edge", ecnt * 2 + 1, exp_q.pop_front());
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    edges(3);
    check("R10 count at reset", count, 0);
    check("R10 cmp_hit at reset", cmp_hit, 0);
    check("R10 ovf_irq at reset", ovf_irq, 0);
    rst_n = 1'b1;

    restart(2'b01, 1'b0, 16'h1234, 1'b1); edges(20);
    check("R3 /2 tap", count, 10);
    rst_n = 1'b0; edges(1);
    check("R10 reset mid-run", count, 0);
    rst_n = 1'b1;

    restart(2'b10, 1'b0, 16'h1234, 1'b1); edges(40);
    check("R3 /8 tap", count, 5);
    restart(2'b11, 1'b0, 16'h1234, 1'b1); edges(100);
    check("R3 /32 tap with prescaler wrap", count, 3);
    restart(2'b00, 1'b0, 16'h1234, 1'b1); edges(50);
    check("R4 no source", count, 0);

    restart(2'b01, 1'b0, 16'h1234, 1'b1); edges(10);
    check("R2 before stop", count, 5);
    psc_run = 1'b0; edges(10);
    check("R2 held while prescaler stopped", count, 5);
    psc_run = 1'b1; edges(10);
    check("R2 prescaler restarts from zero", count, 10);
    cnt_run = 1'b0; edges(1);
    check("R5 run low clears", count, 0);
    edges(4);
    check("R5 stays cleared", count, 0);

    restart(2'b01, 1'b0, 16'h1234, 1'b0);
    for (int i = 0; i < 6; i++) begin
      base_tick = 1'b1; edges(1);
      base_tick = 1'b0; edges(7);
    end
    check("R1 sparse base ticks", count, 3);

    restart(2'b01, 1'b1, 16'd4, 1'b1);
    expect_evt(9, 0); expect_evt(19, 0); expect_evt(29, 0);
    edges(35);
    check("R6 periodic clear", count, 3);

    restart(2'b01, 1'b0, 16'd3, 1'b1);
    expect_evt(7, 0);
    edges(20);
    check("R8 free-run match", count, 10);

    restart(2'b01, 1'b0, 16'h8000, 1'b1);
    expect_evt(65537, 0); expect_evt(131071, 1);
    edges(131075);
    check("R7 wrap past maximum", count, 2);
    check("R8 R9 all expected pulses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule